// File: doc/BRIEF.md
# Pixel Capture and Two-Slot Link Distributor

This block samples parallel pixel data from a display controller, together with horizontal sync, vertical sync and the data-enable flag, and hands the result to a pair of output pixel slots, A and B. Each slot feeds one serializer lane group. A mode code chooses the input arrangement. With two pixels per clock, both input buses are forwarded to their own slots on every clock. With one pixel per clock and a single link, only slot A carries data. With one pixel per clock and two links, consecutive pixels are split between the two slots, so a paired word leaves every other clock.

The capture edge can be selected: either the rising edge or the falling edge of the pixel clock. The data-enable polarity can also be selected. In the split mode, the odd/even pairing is aligned to the start of each active-data run. A one-cycle error pulse reports any blanking interval whose length in clocks is odd, because such an interval breaks the pairing.

Top module: `pix_link_router`

## Requirements
- R1: When `edge_rise` is 1, inputs are captured on the rising clock edge. When it is 0, they are captured on the falling edge. A pixel that is set up before rising edge k and captured on either edge appears at the outputs after rising edge k+1.
- R2: A pixel is active when `de_in` equals `de_pol_high`. Bit 0 of `ctl_out` carries this active flag, normalised to active-high. Bit 2 carries HS and bit 1 carries VS.
- R3: Mode codes 2'b10 and 2'b11 select dual-in/dual-out. On every clock, slot A takes `pix_a_in`, slot B takes `pix_b_in`, and `word_valid` is 1.
- R4: Mode code 2'b00 selects single-in/single-out. Slot A takes `pix_a_in` on every clock with `word_valid` at 1. Slot B is held at zero, and `pix_b_in` has no effect.
- R5: Mode code 2'b01 selects single-in/dual-out. The first pixel of a pair is held and emits nothing. The next pixel completes the pair: slot A gets the held pixel, slot B gets the new one, `ctl_out` takes the held pixel's controls, and `word_valid` pulses once.
- R6: In mode 2'b01, a change from inactive to active always starts a new pair, and the pixel at that change goes to slot A.
- R7: In mode 2'b01, `blank_odd_err` pulses for one word when activity starts after an inactive run of odd length. The first inactive run after reset is not judged. The pulse never appears in other modes.
- R8: While reset is held, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| edge_rise | input | 1 | 1: capture on rising edge, 0: capture on falling edge |
| de_pol_high | input | 1 | 1: data active while DE high, 0: active while DE low |
| link_mode | input | 2 | 00 single/single, 01 single/dual, 10 or 11 dual/dual |
| pix_a_in | input | PIX_W | First (or only) input pixel |
| pix_b_in | input | PIX_W | Second input pixel |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync |
| de_in | input | 1 | Data enable |
| slot_a_out | output | PIX_W | Pixel for link A |
| slot_b_out | output | PIX_W | Pixel for link B |
| ctl_out | output | 3 | {HS, VS, active} of the emitted word |
| word_valid | output | 1 | Output word strobe |
| blank_odd_err | output | 1 | Odd-length blanking interval detected |

## Verification
The riskiest state is the pairing phase in split mode. If it slips by one pixel, the slots swap their odd and even pixels and `word_valid` moves by one clock. The error is then visible on the first paired word after the next activity start. It is also visible at the restart itself, which must hold the first active pixel and emit nothing. A wrong blanking parity bit shows up only at the next inactive-to-active change, as a missing or spurious error pulse. The benches therefore run several blanking lengths, both odd and even. A capture-edge fault shifts data by half a clock, so the bench changes its inputs between the falling and rising edges to expose it on the very next word.

// File: rtl/pix_link_pkg.sv
package pix_link_pkg;

  typedef enum logic [1:0] {
    LM_SGL_SGL   = 2'b00,
    LM_SGL_DUAL  = 2'b01,
    LM_DUAL_DUAL = 2'b10,
    LM_DUAL_ALT  = 2'b11
  } link_mode_e;

  // hs in the top bit, the normalised active flag in the bottom bit
  typedef struct packed {
    logic hs;
    logic vs;
    logic act;
  } ctl_t;

  localparam int CTL_W = 3;

endpackage

// File: rtl/pix_edge_capture.sv
module pix_edge_capture
  import pix_link_pkg::*;
#(
  parameter int PIX_W         = 24,
  parameter bit FALL_CAPT_EN  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_rise,
  input  logic             de_pol_high,
  input  logic [PIX_W-1:0] pix_a,
  input  logic [PIX_W-1:0] pix_b,
  input  logic             hs,
  input  logic             vs,
  input  logic             de,
  output logic [PIX_W-1:0] cap_a,
  output logic [PIX_W-1:0] cap_b,
  output ctl_t             cap_ctl
);

  localparam int VEC_W = 2 * PIX_W + 3;

  logic [VEC_W-1:0] in_vec;
  logic [VEC_W-1:0] fall_vec;
  logic [VEC_W-1:0] pos_q;

  assign in_vec = {pix_b, pix_a, hs, vs, de};

  generate
    if (FALL_CAPT_EN) begin : g_fall
      logic [VEC_W-1:0] neg_q;
      // staging register on the opposite edge, handed to the rising domain
      always_ff @(negedge clk) neg_q <= in_vec;
      assign fall_vec = neg_q;
    end else begin : g_rise_only
      assign fall_vec = in_vec;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pos_q <= '0;
    else     pos_q <= edge_rise ? in_vec : fall_vec;
  end

  assign cap_b       = pos_q[VEC_W-1 -: PIX_W];
  assign cap_a       = pos_q[PIX_W+2 -: PIX_W];
  assign cap_ctl.hs  = pos_q[2];
  assign cap_ctl.vs  = pos_q[1];
  assign cap_ctl.act = de_pol_high ? pos_q[0] : ~pos_q[0];

  assert_rise_capture_R1: assert property (@(posedge clk) disable iff (rst)
    (!rst && edge_rise) |=> (cap_a == $past(pix_a) && cap_b == $past(pix_b)));

endmodule

// File: rtl/pix_pair_splitter.sv
module pix_pair_splitter
  import pix_link_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  link_mode_e       mode,
  input  logic [PIX_W-1:0] cap_a,
  input  logic [PIX_W-1:0] cap_b,
  input  ctl_t             cap_ctl,
  output logic [PIX_W-1:0] slot_a,
  output logic [PIX_W-1:0] slot_b,
  output ctl_t             ctl_o,
  output logic             valid_o
);

  logic             act_q;
  logic             ph_q;      // 1: odd pixel held, waiting for even
  logic [PIX_W-1:0] odd_a_q;
  ctl_t             odd_ctl_q;
  logic             start;
  logic             take_odd;

  assign start    = cap_ctl.act & ~act_q;
  assign take_odd = start | ~ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= 1'b0;
      ph_q      <= 1'b0;
      odd_a_q   <= '0;
      odd_ctl_q <= '0;
      slot_a    <= '0;
      slot_b    <= '0;
      ctl_o     <= '0;
      valid_o   <= 1'b0;
    end else begin
      act_q <= cap_ctl.act;
      case (mode)
        LM_SGL_DUAL: begin
          if (take_odd) begin
            odd_a_q   <= cap_a;
            odd_ctl_q <= cap_ctl;
            ph_q      <= 1'b1;
            valid_o   <= 1'b0;
          end else begin
            slot_a  <= odd_a_q;
            slot_b  <= cap_a;
            ctl_o   <= odd_ctl_q;
            valid_o <= 1'b1;
            ph_q    <= 1'b0;
          end
        end
        LM_SGL_SGL: begin
          slot_a  <= cap_a;
          slot_b  <= '0;
          ctl_o   <= cap_ctl;
          valid_o <= 1'b1;
          ph_q    <= 1'b0;
        end
        default: begin
          slot_a  <= cap_a;
          slot_b  <= cap_b;
          ctl_o   <= cap_ctl;
          valid_o <= 1'b1;
          ph_q    <= 1'b0;
        end
      endcase
    end
  end

  assert_dual_every_clk_R3: assert property (@(posedge clk) disable iff (rst)
    (!rst && (mode == LM_DUAL_DUAL || mode == LM_DUAL_ALT)) |=> valid_o);

  assert_single_b_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!rst && mode == LM_SGL_SGL) |=> (slot_b == '0 && valid_o));

  assert_odd_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (!rst && mode == LM_SGL_DUAL && take_odd) |=> !valid_o);

  assert_restart_phase_R6: assert property (@(posedge clk) disable iff (rst)
    (!rst && mode == LM_SGL_DUAL && start) |=> (ph_q && !valid_o));

endmodule

// File: rtl/blank_parity_mon.sv
module blank_parity_mon
  import pix_link_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  link_mode_e mode,
  input  logic       act,
  output logic       err_o
);

  logic act_q;
  logic par_q;    // parity of inactive clocks since last active pixel
  logic seen_q;   // an active pixel has occurred since reset

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      par_q  <= 1'b0;
      seen_q <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      act_q <= act;
      err_o <= (mode == LM_SGL_DUAL) & act & ~act_q & seen_q & par_q;
      if (act) begin
        par_q  <= 1'b0;
        seen_q <= 1'b1;
      end else begin
        par_q  <= ~par_q;
      end
    end
  end

  assert_err_split_only_R7: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(mode == LM_SGL_DUAL));

  assert_err_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);

endmodule

// File: rtl/pix_link_router.sv
module pix_link_router
  import pix_link_pkg::*;
#(
  parameter int COLOR_BITS   = 8,
  parameter int CHANNELS     = 3,
  parameter bit FALL_CAPT_EN = 1'b1,
  localparam int PIX_W       = COLOR_BITS * CHANNELS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_rise,
  input  logic             de_pol_high,
  input  logic [1:0]       link_mode,
  input  logic [PIX_W-1:0] pix_a_in,
  input  logic [PIX_W-1:0] pix_b_in,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic             de_in,
  output logic [PIX_W-1:0] slot_a_out,
  output logic [PIX_W-1:0] slot_b_out,
  output logic [2:0]       ctl_out,
  output logic             word_valid,
  output logic             blank_odd_err
);

  link_mode_e       mode;
  logic [PIX_W-1:0] cap_a;
  logic [PIX_W-1:0] cap_b;
  ctl_t             cap_ctl;
  ctl_t             ctl_w;

  assign mode = link_mode_e'(link_mode);

  pix_edge_capture #(.PIX_W(PIX_W), .FALL_CAPT_EN(FALL_CAPT_EN)) u_capture (
    .clk(clk), .rst(rst), .edge_rise(edge_rise), .de_pol_high(de_pol_high),
    .pix_a(pix_a_in), .pix_b(pix_b_in), .hs(hs_in), .vs(vs_in), .de(de_in),
    .cap_a(cap_a), .cap_b(cap_b), .cap_ctl(cap_ctl)
  );

  pix_pair_splitter #(.PIX_W(PIX_W)) u_splitter (
    .clk(clk), .rst(rst), .mode(mode),
    .cap_a(cap_a), .cap_b(cap_b), .cap_ctl(cap_ctl),
    .slot_a(slot_a_out), .slot_b(slot_b_out), .ctl_o(ctl_w), .valid_o(word_valid)
  );

  blank_parity_mon u_parity (
    .clk(clk), .rst(rst), .mode(mode), .act(cap_ctl.act), .err_o(blank_odd_err)
  );

  assign ctl_out = ctl_w;

  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> (!word_valid && !blank_odd_err && slot_a_out == '0));

endmodule

// File: tb/test_pix_link_router.sv
`timescale 1ns/1ps
module test_pix_link_router;

  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         edge_rise = 1'b1;
  logic         de_pol_high = 1'b1;
  logic [1:0]   link_mode = 2'b10;
  logic [W-1:0] pix_a_in = '0, pix_b_in = '0;
  logic         hs_in = 1'b0, vs_in = 1'b0, de_in = 1'b0;
  logic [W-1:0] slot_a_out, slot_b_out;
  logic [2:0]   ctl_out;
  logic         word_valid, blank_odd_err;

  pix_link_router i_pix_link_router (
    .clk(clk), .rst(rst), .edge_rise(edge_rise), .de_pol_high(de_pol_high),
    .link_mode(link_mode), .pix_a_in(pix_a_in), .pix_b_in(pix_b_in),
    .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
    .slot_a_out(slot_a_out), .slot_b_out(slot_b_out), .ctl_out(ctl_out),
    .word_valid(word_valid), .blank_odd_err(blank_odd_err)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] ha [0:511];
  logic [W-1:0] hb [0:511];
  logic         hh [0:511];
  logic         hv [0:511];
  logic         hd [0:511];
  int           idx;

  // behavioural expectation state
  logic         m_prev, m_ph, m_seen;
  int           m_blank;
  logic [W-1:0] m_odd_a;
  logic [2:0]   m_odd_ctl;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] gen_a(input int k);
    return W'(k * 24'h010307 + 24'h102030);
  endfunction

  task automatic evaluate(input int j);
    logic act, start;
    logic [2:0] c;
    string base;
    act   = de_pol_high ? hd[j] : ~hd[j];
    start = act & ~m_prev;
    c     = {hh[j], hv[j], act};
    base  = !de_pol_high ? "R2" : (edge_rise ? "R3" : "R1");
    case (link_mode)
      2'b01: begin
        if (start || !m_ph) begin
          check(start ? "R6" : "R5", word_valid, 0);
          m_odd_a = ha[j]; m_odd_ctl = c; m_ph = 1'b1;
        end else begin
          check("R5", word_valid, 1);
          check("R5", slot_a_out, m_odd_a);
          check("R5", slot_b_out, ha[j]);
          check("R5", ctl_out, m_odd_ctl);
          m_ph = 1'b0;
        end
      end
      2'b00: begin
        check("R4", word_valid, 1);
        check("R4", slot_a_out, ha[j]);
        check("R4", slot_b_out, 0);
        check(base, ctl_out, c);
      end
      default: begin
        check(base, word_valid, 1);
        check(base, slot_a_out, ha[j]);
        check(base, slot_b_out, hb[j]);
        check(base, ctl_out, c);
      end
    endcase
    check("R7", blank_odd_err, (link_mode == 2'b01) && start && m_seen && (m_blank % 2 == 1));
    m_prev = act;
    if (act) begin m_blank = 0; m_seen = 1'b1; end
    else m_blank++;
  endtask

  task automatic reset_dut(input logic [1:0] md, input logic pol, input logic rise);
    @(posedge clk); #1;
    link_mode = md; de_pol_high = pol; edge_rise = rise;
    pix_a_in = '0; pix_b_in = '0; hs_in = 0; vs_in = 0; de_in = ~pol;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R8", {slot_a_out, slot_b_out, ctl_out, word_valid, blank_odd_err}, 0);
    rst = 1'b0;
    ha[0] = '0; hb[0] = '0; hh[0] = 0; hv[0] = 0; hd[0] = 0;
    ha[1] = '0; hb[1] = '0; hh[1] = 0; hv[1] = 0; hd[1] = ~pol;
    idx = 0;
    m_prev = 0; m_ph = 0; m_seen = 0; m_blank = 0; m_odd_a = '0; m_odd_ctl = '0;
  endtask

  // one clock: check the word from two entries back, then drive a new pixel;
  // with late set, the bus changes again between the falling and rising edge
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic h, input logic v, input logic d, input logic late);
    @(posedge clk); #1;
    evaluate(idx);
    pix_a_in = a; pix_b_in = b; hs_in = h; vs_in = v; de_in = d;
    ha[idx+2] = a; hb[idx+2] = b;
    if (late) begin
      #2;
      pix_a_in = ~a; pix_b_in = ~b;
      if (edge_rise) begin ha[idx+2] = ~a; hb[idx+2] = ~b; end
    end
    hh[idx+2] = h; hv[idx+2] = v; hd[idx+2] = d;
    idx++;
  endtask

  task automatic run_plain(input int n, input logic late);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] a;
      a = gen_a(k + idx * 3);
      step(a, a ^ 24'hA55AC3, k[1], k[3], (k % 5) != 0, late);
    end
  endtask

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    reset_dut(2'b10, 1, 1); run_plain(30, 0);   // R3
    reset_dut(2'b11, 1, 1); run_plain(20, 0);   // R3 code 11
    reset_dut(2'b00, 1, 1); run_plain(20, 0);   // R4 second bus ignored
    reset_dut(2'b00, 0, 1); run_plain(20, 0);   // R2 active-low enable
    reset_dut(2'b10, 1, 1); run_plain(16, 1);   // R1 rising edge
    reset_dut(2'b10, 1, 0); run_plain(16, 1);   // R1 falling edge
    reset_dut(2'b10, 0, 0); run_plain(12, 1);   // R1 with R2

    // R5 R6 R7: split mode with blanking runs of several lengths
    for (int pass = 0; pass < 2; pass++) begin
      reset_dut(2'b01, 1, pass == 0);
      for (int seg = 0; seg < 10; seg++) begin
        int blank_len, act_len;
        blank_len = (seg * 3 + 4) % 6 + 1;
        act_len   = (seg * 5 + 7) % 8 + 2;
        for (int k = 0; k < blank_len; k++) step(gen_a(idx + 100), '0, 1, k[0], 0, 0);
        for (int k = 0; k < act_len; k++)   step(gen_a(idx + 200), 24'hFFFFFF, 0, k[1], 1, 0);
      end
      for (int k = 0; k < 4; k++) step(gen_a(idx), '0, 0, 0, 0, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule